// File: doc/BRIEF.md
# Thermal Shutdown and Swing Monitor

This block watches two signed temperature codes, one from the power FET and one from the logic area, each scaled at 1 °C per LSB. It applies two separate criteria in parallel. The first is an absolute overtemperature limit on the FET. The second is a limit on how far the FET temperature leads the logic temperature. Each criterion sets a condition when its limit is crossed. The condition releases at a lower point, which gives it hysteresis. Either condition asks the output stage to switch off. While the absolute condition holds, the block also tells the current limiter to use its reduced setpoint.

Both codes are sampled only on a timebase tick. A comparison counts only after it has held on two consecutive samples. This applies to asserting a condition and to releasing it. The thermal fault flag follows the active conditions. It is also hidden once the control input IN has stayed low for a set number of ticks, so a slow PWM on IN does not chop the report. All thresholds and the hold length are parameters.

Top module: `thermal_guard`

## Requirements
- R1: After reset, out_off_o, thermal_fault_o and limit_reduced_o are all 0.
- R2: The shutdown condition becomes active on the second of two consecutive ticks on which fet_temp_i > TSD_SET (default 175). A single hot sample, or two hot samples that are not consecutive, leaves the condition inactive.
- R3: An active shutdown condition releases on the second of two consecutive ticks on which fet_temp_i <= TSD_CLR (default 155). Samples from 156 to 175 keep it active.
- R4: The swing condition becomes active on the second of two consecutive ticks on which fet_temp_i − logic_temp_i > SW_SET (default 60).
- R5: An active swing condition releases on the second of two consecutive ticks on which the difference is < SW_SET − SW_HYS (default 50). A difference of exactly 50 breaks the release run. Release removes the output-off request without any action on IN.
- R6: out_off_o is 1 exactly when at least one of the two conditions is active.
- R7: limit_reduced_o is 1 exactly while the shutdown condition is active. It stays 0 when only the swing condition is active.
- R8: thermal_fault_o is 1 while a condition is active and IN has not been held low for the hold time. It returns to 0 when the conditions release.
- R9: thermal_fault_o drops to 0 on the HOLD_TICKS-th (default 8) consecutive tick with in_i low, even if a condition is still active. out_off_o stays 1. The fault returns on the clock edge after in_i goes high again.
- R10: Temperature inputs have no effect on cycles where tick_i is 0.
- R11: Both codes are two's complement. A negative logic temperature produces the correct positive difference for the swing check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Timebase tick; enables sampling and hold counting |
| fet_temp_i | input | TEMP_W | Signed FET temperature code, 1 °C/LSB |
| logic_temp_i | input | TEMP_W | Signed logic-area temperature code, 1 °C/LSB |
| in_i | input | 1 | Output enable request from the controller |
| out_off_o | output | 1 | Request to switch the output off |
| thermal_fault_o | output | 1 | Thermal fault report |
| limit_reduced_o | output | 1 | Select reduced current-limit setpoint |

## Verification
The hardest situation to reach from the ports is a release run that is broken by a sample sitting exactly on the release boundary. The stimulus therefore steps the codes through a planned sequence: a hot sample, a cool sample and a hot sample again, then a release sample, a sample one degree above it, and a second release pair. Each step probes the two-sample qualifier on both the set side and the clear side. The fault-hold mask needs a condition held active while IN stays low through exactly the hold count. The bench checks one tick short of the count and then the tick that completes it.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;
  typedef enum int unsigned {
    COND_TSD   = 0,
    COND_SWING = 1
  } cond_e;
  localparam int unsigned NUM_COND = 2;
endpackage

// File: rtl/thermal_hyst_cell.sv
// Two-sample qualified set/clear latch for one thermal criterion.
module thermal_hyst_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic set_hit_i,
  input  logic clr_hit_i,
  output logic active_o
);
  logic set_seen_q, clr_seen_q, active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_seen_q <= 1'b0;
      clr_seen_q <= 1'b0;
      active_q   <= 1'b0;
    end else if (tick_i) begin
      set_seen_q <= set_hit_i;
      clr_seen_q <= clr_hit_i;
      if (!active_q && set_hit_i && set_seen_q)     active_q <= 1'b1;
      else if (active_q && clr_hit_i && clr_seen_q) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/thermal_hold_timer.sv
// Counts ticks with IN low; saturates at HOLD_TICKS and masks the fault report.
module thermal_hold_timer #(
  parameter int HOLD_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic in_i,
  output logic masked_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (in_i)                       cnt_q <= '0;
    else if (tick_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign masked_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_guard_pkg::*;
#(
  parameter int TEMP_W     = 10,
  parameter int TSD_SET    = 175,
  parameter int TSD_CLR    = 155,
  parameter int SW_SET     = 60,
  parameter int SW_HYS     = 10,
  parameter int HOLD_TICKS = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic signed [TEMP_W-1:0] fet_temp_i,
  input  logic signed [TEMP_W-1:0] logic_temp_i,
  input  logic                     in_i,
  output logic                     out_off_o,
  output logic                     thermal_fault_o,
  output logic                     limit_reduced_o
);
  localparam int SW_CLR = SW_SET - SW_HYS;

  logic signed [TEMP_W:0] diff_w;
  logic [NUM_COND-1:0]    set_hit, clr_hit, active;
  logic                   fault_mask;

  // one extra bit so the difference never wraps
  assign diff_w = $signed({fet_temp_i[TEMP_W-1], fet_temp_i})
                - $signed({logic_temp_i[TEMP_W-1], logic_temp_i});

  always_comb begin
    set_hit[COND_TSD]   = fet_temp_i > TSD_SET;
    clr_hit[COND_TSD]   = fet_temp_i <= TSD_CLR;
    set_hit[COND_SWING] = diff_w > SW_SET;
    clr_hit[COND_SWING] = diff_w < SW_CLR;
  end

  for (genvar g = 0; g < NUM_COND; g++) begin : g_cond
    thermal_hyst_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_i),
      .set_hit_i (set_hit[g]),
      .clr_hit_i (clr_hit[g]),
      .active_o  (active[g])
    );
  end

  thermal_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .in_i     (in_i),
    .masked_o (fault_mask)
  );

  assign out_off_o       = |active;
  assign limit_reduced_o = active[COND_TSD];
  assign thermal_fault_o = (|active) && !fault_mask;
endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk #(
  parameter int TEMP_W  = 10,
  parameter int TSD_SET = 175,
  parameter int TSD_CLR = 155,
  parameter int SW_SET  = 60
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     tick_i,
  input logic signed [TEMP_W-1:0] fet_temp_i,
  input logic signed [TEMP_W-1:0] logic_temp_i,
  input logic                     out_off_o,
  input logic                     thermal_fault_o,
  input logic                     limit_reduced_o
);
  logic signed [TEMP_W:0] chk_diff;
  assign chk_diff = $signed({fet_temp_i[TEMP_W-1], fet_temp_i})
                  - $signed({logic_temp_i[TEMP_W-1], logic_temp_i});

  // R2
  tsd_rise_hot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(limit_reduced_o) |-> ($past(tick_i) && $past(fet_temp_i) > TSD_SET));

  // R3
  tsd_fall_cool_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(limit_reduced_o) |-> ($past(tick_i) && $past(fet_temp_i) <= TSD_CLR));

  // R4
  swing_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(out_off_o) && !limit_reduced_o) |-> $past(chk_diff) > SW_SET);

  // R10
  no_tick_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(out_off_o) && $stable(limit_reduced_o)));

  // R8
  fault_needs_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thermal_fault_o |-> out_off_o);

  // R7
  reduced_implies_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limit_reduced_o |-> out_off_o);
endmodule

bind thermal_guard thermal_guard_chk #(
  .TEMP_W (TEMP_W),
  .TSD_SET(TSD_SET),
  .TSD_CLR(TSD_CLR),
  .SW_SET (SW_SET)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tick_i         (tick_i),
  .fet_temp_i     (fet_temp_i),
  .logic_temp_i   (logic_temp_i),
  .out_off_o      (out_off_o),
  .thermal_fault_o(thermal_fault_o),
  .limit_reduced_o(limit_reduced_o)
);

// File: tb/thermal_guard_tb.sv
module thermal_guard_tb;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic in_s = 1'b1;
  logic signed [W-1:0] fet = '0;
  logic signed [W-1:0] lgc = '0;
  logic out_off, fault, reduced;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  thermal_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .fet_temp_i(fet), .logic_temp_i(lgc), .in_i(in_s),
    .out_off_o(out_off), .thermal_fault_o(fault), .limit_reduced_o(reduced)
  );

  // {fet[9:0], logic[9:0], in, off, fault, reduced}
  function automatic logic [23:0] mk(int f, int l, bit i, bit o, bit fl, bit r);
    logic [9:0] fb, lb;
    fb = f[9:0];
    lb = l[9:0];
    return {fb, lb, i, o, fl, r};
  endfunction

  localparam int N = 21;
  localparam logic [23:0] VEC [N] = '{
    mk( 25,  20, 1, 0, 0, 0),  // baseline
    mk(180, 170, 1, 0, 0, 0),  // R2 first hot sample
    mk(100,  95, 1, 0, 0, 0),  // R2 run broken
    mk(180, 170, 1, 0, 0, 0),
    mk(176, 170, 1, 1, 1, 1),  // R2 R6 R7 R8 asserted
    mk(160, 150, 1, 1, 1, 1),  // R3 in band
    mk(155, 150, 1, 1, 1, 1),  // R3 first release sample
    mk(156, 150, 1, 1, 1, 1),  // R3 run broken
    mk(150, 140, 1, 1, 1, 1),
    mk(155, 140, 1, 0, 0, 0),  // R3 R8 released
    mk(100,  30, 1, 0, 0, 0),  // R4 first
    mk(100,  35, 1, 1, 1, 0),  // R4 R7 swing only
    mk(100,  45, 1, 1, 1, 0),
    mk(100,  51, 1, 1, 1, 0),  // R5 diff 49
    mk(100,  50, 1, 1, 1, 0),  // R5 diff 50 breaks
    mk(100,  55, 1, 1, 1, 0),
    mk(100,  60, 1, 0, 0, 0),  // R5 self-recover
    mk( 20, -45, 1, 0, 0, 0),  // R11 diff 65
    mk( 20, -50, 1, 1, 1, 0),  // R11 swing
    mk( 20,  10, 1, 1, 1, 0),
    mk( 20,  10, 1, 0, 0, 0)
  };

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: {off,fault,reduced} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(int f, int l, bit i, bit tk);
    fet  = f[W-1:0];
    lgc  = l[W-1:0];
    in_s = i;
    tick = tk;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {out_off, fault, reduced}, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_off, fault, reduced}, 3'b000);

    for (int k = 0; k < N; k++) begin
      step($signed(VEC[k][23:14]), $signed(VEC[k][13:4]), VEC[k][3], 1'b1);
      check($sformatf("R2-R8/R11 vec%0d", k), {out_off, fault, reduced}, VEC[k][2:0]);
    end

    // R10 hot codes without tick have no effect
    for (int k = 0; k < 5; k++) step(300, -100, 1, 0);
    check("R10", {out_off, fault, reduced}, 3'b000);

    // R9 fault hold mask
    step(200, 190, 1, 1);
    step(200, 190, 1, 1);
    check("R9 active", {out_off, fault, reduced}, 3'b111);
    for (int k = 0; k < 7; k++) step(200, 190, 0, 1);
    check("R9 seven ticks low", {out_off, fault, reduced}, 3'b111);
    step(200, 190, 0, 1);
    check("R9 eighth tick masks", {out_off, fault, reduced}, 3'b101);
    step(200, 190, 1, 0);
    check("R9 IN high restores", {out_off, fault, reduced}, 3'b111);
    step(100, 95, 1, 1);
    step(100, 95, 1, 1);
    check("R3 R8 release", {out_off, fault, reduced}, 3'b000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule